// File: doc/BRIEF.md
# Iterative Whirlpool Compression Engine

This block runs the Whirlpool compression function on one 512-bit message block at a time and keeps the 64-byte chaining value between blocks. It is built for small area. A single S-box and a single shared column-shift/row-mix slice carry all of the work. A counter steps through the ten cipher rounds, and each round substitutes one byte per cycle.

A producer presents a block that has already been padded, together with a flag that marks the final block of a message. The block is taken in a cycle where `busy` is low and `blk_valid` is high. `busy` then stays high until the chaining value has been updated. After the final block, `dig_valid` pulses for one cycle, and `dig_data` holds the 512-bit digest until the next update. The next message begins again from an all-zero chaining value.

Each round has three parts. In the substitution part, 8 cycles build the round constant from consecutive S-box outputs, 64 cycles substitute the key bytes and 64 cycles substitute the state bytes. One cycle then mixes the key and one cycle mixes the state. The finalize cycle XORs the cipher output with the old chaining value and the message.

Top module: `whirl_compress`

## Requirements
- R1: After reset, `busy` is low, `dig_valid` is low and `dig_data` is all zeros.
- R2: A block is accepted on a clock edge where `blk_valid` is high and `busy` is low, and `busy` is high in the next cycle. While `busy` is high, `blk_valid`, `blk_last` and `blk_data` have no effect on any result.
- R3: After an accepting edge, `busy` stays high for exactly 1381 cycles: 10 rounds of 138 cycles each, plus one finalize cycle.
- R4: The substitution uses the structured S-box built from 4-bit sub-boxes. For a single final block holding the padded empty message (byte 0 = 0x80, all other bytes zero), the digest is 19FA61D7...42A66EB3, the standard Whirlpool digest of the empty string.
- R5: Byte k of `blk_data` and of `dig_data` sits at bits [511-8k -: 8] and is the matrix element at row k/8, column k%8. Each block updates the chaining value H to W xor H xor M, where W is the 10-round cipher output of M keyed by H. For messages of several blocks, the final digest equals this recurrence applied in order.
- R6: `dig_valid` is a single-cycle pulse. It appears in the first cycle with `busy` low after a block marked last, and never after a block that is not marked last.
- R7: `dig_data` changes only on the finalize edge of a block. It keeps its value while a later block is being processed.
- R8: Every message starts from an all-zero chaining value. This holds even when the first block of the next message is accepted in the same cycle that `dig_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | A block is offered |
| blk_last | input | 1 | The offered block ends its message |
| blk_data | input | 512 | Padded message block, byte 0 in the top bits |
| busy | output | 1 | Engine is working on a block; input is not taken |
| dig_valid | output | 1 | One-cycle pulse: digest is ready |
| dig_data | output | 512 | Current chaining value / digest, byte 0 in the top bits |

## Verification
Two events can fall in the same cycle: the digest pulse of one message and the acceptance of the first block of the next message. The collision is provoked by raising `blk_valid` with the next block while the final block is still being processed, and holding it there. The block is then ignored through the finalize cycle and taken on the very edge where `dig_valid` is high. The bench judges the outcome in three ways: the pulse and the old digest are seen in that cycle, `busy` rises one cycle later, and the second digest matches a reference computed from a zero chaining value, not from the first digest.

// File: rtl/whirl_compress.sv
module whirl_compress #(
  parameter int ROUNDS = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         blk_valid,
  input  logic         blk_last,
  input  logic [511:0] blk_data,
  output logic         busy,
  output logic         dig_valid,
  output logic [511:0] dig_data
);
  localparam logic [63:0] EBOX = 64'h1B9CD6F3E874A250;
  localparam logic [63:0] EINV = 64'hF0D7BE5A92C13486;
  localparam logic [63:0] RBOX = 64'h7CBDE49F638A2510;
  localparam logic [31:0] CIRC = 32'h11418529;
  localparam logic [7:0]  SUB_END = 8'd135;

  typedef enum logic [2:0] {IDLE, SUB, MIXK, MIXS, FIN} ph_t;

  function automatic logic [3:0] nib(input logic [63:0] t, input logic [3:0] x);
    return t[{~x, 2'b11} -: 4];
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] u);
    logic [3:0] a, b, r;
    a = nib(EBOX, u[7:4]);
    b = nib(EINV, u[3:0]);
    r = nib(RBOX, a ^ b);
    return {nib(EBOX, a ^ r), nib(EINV, b ^ r)};
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [3:0] c);
    logic [7:0] x, p;
    x = a;
    p = '0;
    for (int n = 0; n < 4; n++) begin
      if (c[n]) p ^= x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1D : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [511:0] shift_mix(input logic [511:0] a);
    logic [511:0] o;
    logic [7:0] acc;
    o = '0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        acc = '0;
        for (int q = 0; q < 8; q++)
          acc ^= gf_mul(a[511 - 8*(8*((i - q) & 7) + q) -: 8],
                        CIRC[31 - 4*((j - q) & 7) -: 4]);
        o[511 - 8*(8*i + j) -: 8] = acc;
      end
    return o;
  endfunction

  ph_t          ph;
  logic [511:0] h, m, k, s;
  logic [63:0]  rc;
  logic [7:0]   cnt;
  logic [3:0]   rnd;
  logic         last_q, fresh, dv;

  wire [511:0] chain   = fresh ? '0 : h;
  wire [5:0]   kidx    = 6'(cnt - 8'd8);
  wire [5:0]   sidx    = 6'(cnt - 8'd72);
  wire [7:0]   sin     = (cnt < 8'd8)  ? {1'b0, rnd[3:0], cnt[2:0]} :
                         (cnt < 8'd72) ? k[{~kidx, 3'b111} -: 8] :
                                         s[{~sidx, 3'b111} -: 8];
  wire [7:0]   sout    = sbox(sin);
  wire [511:0] mix_out = shift_mix(ph == MIXK ? k : s);

  assign busy      = (ph != IDLE);
  assign dig_valid = dv;
  assign dig_data  = h;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= IDLE; h <= '0; m <= '0; k <= '0; s <= '0; rc <= '0;
      cnt <= '0; rnd <= '0; last_q <= 1'b0; fresh <= 1'b1; dv <= 1'b0;
    end else begin
      dv <= 1'b0;
      case (ph)
        IDLE: if (blk_valid) begin
          m <= blk_data; k <= chain; s <= blk_data ^ chain;
          last_q <= blk_last; cnt <= '0; rnd <= '0; ph <= SUB;
        end
        SUB: begin
          if (cnt < 8'd8)       rc[{~cnt[2:0], 3'b111} -: 8] <= sout;
          else if (cnt < 8'd72) k[{~kidx, 3'b111} -: 8] <= sout;
          else                  s[{~sidx, 3'b111} -: 8] <= sout;
          if (cnt == SUB_END) ph <= MIXK;
          cnt <= cnt + 8'd1;
        end
        MIXK: begin
          k  <= mix_out ^ {rc, 448'b0};
          ph <= MIXS;
        end
        MIXS: begin
          s   <= mix_out ^ k;
          cnt <= '0;
          if (rnd == 4'(ROUNDS - 1)) ph <= FIN;
          else begin rnd <= rnd + 4'd1; ph <= SUB; end
        end
        FIN: begin
          h <= s ^ chain ^ m;
          fresh <= last_q;
          dv <= last_q;
          ph <= IDLE;
        end
        default: ph <= IDLE;
      endcase
    end
  end

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !busy) |=> busy);
  p_fin_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == FIN) |=> !busy);
  p_round_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd < 4'(ROUNDS)) && (cnt <= SUB_END + 8'd1));
  p_dig_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid |=> !dig_valid);
  p_dig_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dig_valid |-> !busy);
  p_dig_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ph != FIN) |=> $stable(dig_data));
endmodule

// File: tb/whirl_compress_tb.sv
`timescale 1ns/1ps
module whirl_compress_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_valid = 1'b0, blk_last = 1'b0;
  logic [511:0] blk_data = '0;
  logic busy, dig_valid;
  logic [511:0] dig_data;
  int nchk = 0, nfail = 0;
  logic [7:0] sb [256];

  always #4 clk = ~clk;

  whirl_compress u_dut (.clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_last(blk_last),
    .blk_data(blk_data), .busy(busy), .dig_valid(dig_valid), .dig_data(dig_data));

  localparam logic [511:0] EMPTY_DIG = 512'h19FA61D75522A4669B44E39C1D2E1726_C530232130D407F89AFEE0964997F7A7_3E83BE698B288FEBCF88E3E03C4F0757_EA8964E59B63D93708B138CC42A66EB3;

  function automatic logic [3:0] lut(input logic [63:0] t, input int x);
    return t[63 - 4*x -: 4];
  endfunction

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = '0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= a;
      a = {a[6:0], 1'b0} ^ (a[7] ? 8'h1D : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] coef(input int d);
    case (d)
      0, 1, 3: return 8'd1;
      2: return 8'd4;
      4: return 8'd8;
      5: return 8'd5;
      6: return 8'd2;
      default: return 8'd9;
    endcase
  endfunction

  function automatic logic [7:0] byt(input logic [511:0] v, input int r, input int c);
    return v[511 - 8*(8*r + c) -: 8];
  endfunction

  function automatic logic [511:0] rho(input logic [511:0] a, input logic [511:0] kk);
    logic [7:0] p [8][8];
    logic [511:0] o = '0;
    logic [7:0] t;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        p[(r + c) % 8][c] = sb[byt(a, r, c)];
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        t = byt(kk, r, c);
        for (int x = 0; x < 8; x++) t ^= gm(p[r][x], coef((c - x + 8) % 8));
        o[511 - 8*(8*r + c) -: 8] = t;
      end
    return o;
  endfunction

  function automatic logic [511:0] ref_comp(input logic [511:0] hv, input logic [511:0] mv);
    logic [511:0] kk = hv, st = mv ^ hv, rcv;
    for (int r = 1; r <= 10; r++) begin
      rcv = '0;
      for (int j = 0; j < 8; j++) rcv[511 - 8*j -: 8] = sb[8*(r-1) + j];
      kk = rho(kk, rcv);
      st = rho(st, kk);
    end
    return st ^ hv ^ mv;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [511:0] d, input bit last);
    @(negedge clk);
    while (busy) @(negedge clk);
    blk_valid = 1'b1; blk_data = d; blk_last = last;
    @(negedge clk);
    blk_valid = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (busy) begin @(negedge clk); n++; end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [511:0] a, b, hv, hold, blks [3];
    logic [63:0] e, ei, rb;
    logic [3:0] x, y, z;
    int n;
    e = 64'h1B9CD6F3E874A250; ei = 64'hF0D7BE5A92C13486; rb = 64'h7CBDE49F638A2510;
    for (int u = 0; u < 256; u++) begin
      x = lut(e, u / 16); y = lut(ei, u % 16); z = lut(rb, int'(x ^ y));
      sb[u] = {lut(e, int'(x ^ z)), lut(ei, int'(y ^ z))};
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", 512'(busy), 512'd0);
    chk(dig_valid == 1'b0, "R1 dig_valid after reset", 512'(dig_valid), 512'd0);
    chk(dig_data == '0, "R1 dig_data after reset", dig_data, '0);

    // R4: padded empty message, known digest; also cross-checks the model
    a = {8'h80, 504'b0};
    chk(ref_comp('0, a) == EMPTY_DIG, "R4 model vs known vector", ref_comp('0, a), EMPTY_DIG);
    send(a, 1'b1);
    chk(busy == 1'b1, "R2 busy after accept", 512'(busy), 512'd1);
    wait_done(n);
    chk(n == 1381, "R3 busy length", 512'(n), 512'd1381);
    chk(dig_valid == 1'b1, "R6 pulse after last", 512'(dig_valid), 512'd1);
    chk(dig_data == EMPTY_DIG, "R4 empty digest", dig_data, EMPTY_DIG);
    @(negedge clk);
    chk(dig_valid == 1'b0, "R6 pulse one cycle", 512'(dig_valid), 512'd0);
    chk(dig_data == EMPTY_DIG, "R7 digest held while idle", dig_data, EMPTY_DIG);

    // R5: "abc" padded, byte order check
    a = {8'h61, 8'h62, 8'h63, 8'h80, 496'b0};
    a[7:0] = 8'h18;
    send(a, 1'b1);
    wait_done(n);
    chk(dig_data == ref_comp('0, a), "R5 abc block", dig_data, ref_comp('0, a));

    // R5/R6/R7: three-block messages, sweep
    for (int t = 0; t < 3; t++) begin
      hv = '0;
      for (int i = 0; i < 3; i++) blks[i] = rnd512();
      for (int i = 0; i < 3; i++) begin
        hold = dig_data;
        send(blks[i], i == 2);
        chk(dig_data == hold, "R7 digest stable during processing", dig_data, hold);
        wait_done(n);
        chk(n == 1381, "R3 busy length multi", 512'(n), 512'd1381);
        hv = ref_comp(hv, blks[i]);
        chk(dig_valid == (i == 2), "R6 pulse only on last", 512'(dig_valid), 512'(i == 2));
        chk(dig_data == hv, "R5 chained value", dig_data, hv);
      end
    end

    // single-block sweep
    for (int t = 0; t < 4; t++) begin
      a = rnd512();
      send(a, 1'b1);
      wait_done(n);
      chk(dig_data == ref_comp('0, a), "R8 single block from zero chain", dig_data, ref_comp('0, a));
    end

    // R2: input activity while busy is ignored
    a = rnd512();
    send(a, 1'b1);
    blk_valid = 1'b1; blk_last = 1'b0; blk_data = rnd512();
    repeat (600) @(negedge clk);
    blk_valid = 1'b0;
    wait_done(n);
    chk(n == 1381 - 600, "R2 busy length unaffected", 512'(n), 512'(1381 - 600));
    chk(dig_valid == 1'b1, "R2 last flag unaffected", 512'(dig_valid), 512'd1);
    chk(dig_data == ref_comp('0, a), "R2 data ignored while busy", dig_data, ref_comp('0, a));

    // R8: next block accepted in the dig_valid cycle
    a = rnd512(); b = rnd512();
    send(a, 1'b1);
    blk_valid = 1'b1; blk_last = 1'b1; blk_data = b;
    wait_done(n);
    chk(dig_valid == 1'b1, "R8 pulse in collision cycle", 512'(dig_valid), 512'd1);
    chk(dig_data == ref_comp('0, a), "R8 first digest", dig_data, ref_comp('0, a));
    @(negedge clk);
    blk_valid = 1'b0;
    chk(busy == 1'b1, "R8 accepted on pulse cycle", 512'(busy), 512'd1);
    chk(dig_data == ref_comp('0, a), "R7 digest held into next message", dig_data, ref_comp('0, a));
    wait_done(n);
    chk(n == 1381, "R3 busy length back-to-back", 512'(n), 512'd1381);
    chk(dig_data == ref_comp('0, b), "R8 zero chain after collision", dig_data, ref_comp('0, b));

    summary();
    $finish;
  end
endmodule